// File: doc/BRIEF.md
# Programmable Flag Threshold Loader

This block holds the two threshold offsets that a FIFO's almost-empty and almost-full flags are compared against, and gives the surrounding logic a way to set and inspect them. The offsets sit in two registers, each as wide as the FIFO address. The comparison against fill level and the FIFO storage itself live elsewhere.

While master reset is held, the load-select input `loadSel` is sampled on every write-clock edge. It decides two things at once. Low selects the small default of 127 for both offsets and parallel programming. High selects the large default of 1023 for both and serial programming. After reset, the offsets are changed either one bit at a time from `serIn` or one word at a time from `din`, depending on that choice. In parallel mode, writes go to the almost-empty register first, then the almost-full register, and then alternate. The read port on its own clock returns the offsets on `dout` in the same alternating order, with its own pointer, whichever programming method is active.

A partial reset returns the sequencing state to its starting point. It keeps the offsets and the programming method.

Top module: `flag_offset_prog`

## Requirements
- R1: While `mrsN` is low, a write-clock edge with `loadSel`=0 sets both offsets to 127 and selects parallel mode, and an edge with `loadSel`=1 sets both to 1023 and selects serial mode. This overrides any earlier programming.
- R2: In parallel mode, a write-clock edge with `wrEn` and `ld` both high stores `din[ADDR_W-1:0]` into one offset. The target alternates almost-empty, almost-full, almost-empty, and so on, starting at almost-empty.
- R3: A write-clock edge with only one of `wrEn`/`ld` high, or any parallel write attempt in serial mode, leaves both offsets unchanged.
- R4: In serial mode, each write-clock edge with `serEn` and `ld` both high stores `serIn` into the next offset bit, least significant bit first. Bits 0 to ADDR_W-1 of almost-empty are filled, then bits 0 to ADDR_W-1 of almost-full, and then the sequence wraps to almost-empty bit 0.
- R5: In parallel mode, serial strobes (`serEn` with `ld`) leave both offsets unchanged.
- R6: A read-clock edge with `rdEn` and `ld` both high loads `dout` with the next offset, zero-extended to DATA_W. The order alternates almost-empty, almost-full, starting at almost-empty. `dout` holds its value on all other read-clock edges.
- R7: Readback works the same way in serial mode as in parallel mode.
- R8: Partial reset (`prsN` low) keeps both offsets and the programming method. It returns the parallel write pointer, the read pointer and the serial bit position to almost-empty bit 0.
- R9: Master reset clears `dout` to zero and returns all sequence pointers to the almost-empty register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock for programming |
| rdClk | input | 1 | Read-side clock for readback |
| mrsN | input | 1 | Master reset, active low, sampled synchronously in both domains |
| prsN | input | 1 | Partial reset, active low, sampled synchronously in both domains |
| loadSel | input | 1 | Default and method select, sampled during master reset |
| ld | input | 1 | Offset access qualifier for all programming and readback |
| wrEn | input | 1 | Parallel write strobe |
| din | input | DATA_W | Parallel offset data; the low ADDR_W bits are used |
| serEn | input | 1 | Serial shift strobe |
| serIn | input | 1 | Serial offset bit |
| rdEn | input | 1 | Readback strobe |
| dout | output | DATA_W | Readback offset, zero-extended |

## Verification
The hardest case to reach is the serial bit position crossing from the last bit of one register into the next. This includes the wrap from almost-full back to almost-empty bit 0, which needs more than two full register loads in one run. The stimulus shifts 2·ADDR_W bits and then a few more, so the wrap overwrites only the low bits of almost-empty, and checks both registers by readback. A partial reset is also issued in the middle of a serial load. The bench then confirms that the next shifted bit lands at almost-empty bit 0, and that parallel writes are still ignored because the mode survived the reset.

// File: rtl/flagofs_pkg.sv
package flagofs_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadDefaults; // master reset in progress
    logic defLarge;     // pick the large default set
    logic wrAe;         // parallel write to almost-empty
    logic wrAf;         // parallel write to almost-full
    logic shiftAe;      // serial bit into almost-empty
    logic shiftAf;      // serial bit into almost-full
    logic rdClear;      // clear readback register
    logic rdLoad;       // readback capture
    logic rdSelAf;      // readback source is almost-full
  } ofsStrobe_t;

endpackage

// File: rtl/flagofs_ctrl.sv
module flagofs_ctrl
  import flagofs_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int BITS  = 2 * ADDR_W,
  localparam int CNT_W = $clog2(BITS),
  localparam int POS_W = $clog2(ADDR_W)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             mrsN,
  input  logic             prsN,
  input  logic             loadSel,
  input  logic             ld,
  input  logic             wrEn,
  input  logic             serEn,
  input  logic             rdEn,
  output ofsStrobe_t       st,
  output logic [POS_W-1:0] bitPos
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS - 1);
  localparam logic [CNT_W-1:0] HALF     = CNT_W'(ADDR_W);

  logic             serialMode;
  logic             wrPtr;
  logic             rdPtr;
  logic [CNT_W-1:0] bitCnt;
  logic             parWr;
  logic             serWr;
  logic             inAf;

  assign parWr = mrsN && prsN && !serialMode && wrEn && ld;
  assign serWr = mrsN && prsN && serialMode && serEn && ld;
  assign inAf  = (bitCnt >= HALF);

  // Write-domain sequencing
  always_ff @(posedge wrClk) begin
    if (!mrsN) begin
      serialMode <= loadSel;
      wrPtr      <= 1'b0;
      bitCnt     <= '0;
    end else if (!prsN) begin
      wrPtr      <= 1'b0;
      bitCnt     <= '0;
    end else begin
      if (parWr) wrPtr <= ~wrPtr;
      if (serWr) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end
  end

  // Read-domain sequencing
  always_ff @(posedge rdClk) begin
    if (!mrsN || !prsN) rdPtr <= 1'b0;
    else if (rdEn && ld) rdPtr <= ~rdPtr;
  end

  always_comb begin
    bitPos = inAf ? POS_W'(bitCnt - HALF) : POS_W'(bitCnt);
  end

  always_comb begin
    st.loadDefaults = !mrsN;
    st.defLarge     = loadSel;
    st.wrAe         = parWr && !wrPtr;
    st.wrAf         = parWr && wrPtr;
    st.shiftAe      = serWr && !inAf;
    st.shiftAf      = serWr && inAf;
    st.rdClear      = !mrsN;
    st.rdLoad       = mrsN && prsN && rdEn && ld;
    st.rdSelAf      = rdPtr;
  end

  // R3: at most one register write per cycle
  a_r3_single_target: assert property (@(posedge wrClk) disable iff (!mrsN)
    $onehot0({st.wrAe, st.wrAf, st.shiftAe, st.shiftAf}));

  // R2: the parallel target changes after every accepted write
  a_r2_ptr_alternates: assert property (@(posedge wrClk) disable iff (!mrsN || !prsN)
    parWr |=> (wrPtr != $past(wrPtr)));

  // R4: the serial position wraps from the last almost-full bit to zero
  a_r4_bit_wrap: assert property (@(posedge wrClk) disable iff (!mrsN || !prsN)
    (serWr && bitCnt == LAST_BIT) |=> (bitCnt == '0));

  // R8: partial reset keeps the method
  a_r8_mode_kept: assert property (@(posedge wrClk) disable iff (!mrsN)
    !prsN |=> (serialMode == $past(serialMode)));

endmodule

// File: rtl/flagofs_datapath.sv
module flagofs_datapath
  import flagofs_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 18,
  parameter int DEF_SMALL = 127,
  parameter int DEF_LARGE = 1023,
  localparam int POS_W    = $clog2(ADDR_W)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  ofsStrobe_t        st,
  input  logic [POS_W-1:0]  bitPos,
  input  logic [ADDR_W-1:0] wrWord,
  input  logic              serIn,
  output logic [DATA_W-1:0] dout
);

  localparam logic [ADDR_W-1:0] SMALL_V = ADDR_W'(DEF_SMALL);
  localparam logic [ADDR_W-1:0] LARGE_V = ADDR_W'(DEF_LARGE);

  logic [ADDR_W-1:0] aeOfs;
  logic [ADDR_W-1:0] afOfs;
  logic [ADDR_W-1:0] rdSrc;

  always_ff @(posedge wrClk) begin
    if (st.loadDefaults) begin
      aeOfs <= st.defLarge ? LARGE_V : SMALL_V;
      afOfs <= st.defLarge ? LARGE_V : SMALL_V;
    end else begin
      if (st.wrAe)    aeOfs <= wrWord;
      if (st.wrAf)    afOfs <= wrWord;
      if (st.shiftAe) aeOfs[bitPos] <= serIn;
      if (st.shiftAf) afOfs[bitPos] <= serIn;
    end
  end

  assign rdSrc = st.rdSelAf ? afOfs : aeOfs;

  always_ff @(posedge rdClk) begin
    if (st.rdClear)     dout <= '0;
    else if (st.rdLoad) dout <= DATA_W'(rdSrc);
  end

  // R6: readback output holds without a strobe
  a_r6_dout_holds: assert property (@(posedge rdClk) disable iff (st.rdClear)
    !st.rdLoad |=> $stable(dout));

  // R1: defaults follow the select sampled in reset
  a_r1_defaults: assert property (@(posedge wrClk) disable iff (!st.loadDefaults)
    1'b1 |=> (aeOfs == ($past(st.defLarge) ? LARGE_V : SMALL_V)) && (afOfs == aeOfs));

  // R5: no strobe, no change in the offsets
  a_r5_offsets_hold: assert property (@(posedge wrClk) disable iff (st.loadDefaults)
    !(st.wrAe || st.wrAf || st.shiftAe || st.shiftAf) |=> ($stable(aeOfs) && $stable(afOfs)));

endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog
  import flagofs_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 18,
  parameter int DEF_SMALL = 127,
  parameter int DEF_LARGE = 1023
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrsN,
  input  logic              prsN,
  input  logic              loadSel,
  input  logic              ld,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] din,
  input  logic              serEn,
  input  logic              serIn,
  input  logic              rdEn,
  output logic [DATA_W-1:0] dout
);

  localparam int POS_W = $clog2(ADDR_W);

  ofsStrobe_t       st;
  logic [POS_W-1:0] bitPos;

  generate
    if (DATA_W > ADDR_W) begin : g_hi
      logic unusedHiBits;
      assign unusedHiBits = ^din[DATA_W-1:ADDR_W];
    end
  endgenerate

  flagofs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrClk  (wrClk),
    .rdClk  (rdClk),
    .mrsN   (mrsN),
    .prsN   (prsN),
    .loadSel(loadSel),
    .ld     (ld),
    .wrEn   (wrEn),
    .serEn  (serEn),
    .rdEn   (rdEn),
    .st     (st),
    .bitPos (bitPos)
  );

  flagofs_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DEF_SMALL(DEF_SMALL),
    .DEF_LARGE(DEF_LARGE)
  ) u_dp (
    .wrClk (wrClk),
    .rdClk (rdClk),
    .st    (st),
    .bitPos(bitPos),
    .wrWord(din[ADDR_W-1:0]),
    .serIn (serIn),
    .dout  (dout)
  );

  // R9: master reset clears the readback output
  a_r9_reset_clears: assert property (@(posedge rdClk)
    !mrsN |=> (dout == '0));

endmodule

// File: tb/flag_offset_prog_bench.sv
module flag_offset_prog_bench;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 18;

  logic wrClk = 1'b0;
  logic rdClk = 1'b0;
  logic mrsN = 1'b0, prsN = 1'b1, loadSel = 1'b0, ld = 1'b0;
  logic wrEn = 1'b0, serEn = 1'b0, serIn = 1'b0, rdEn = 1'b0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;

  int compared = 0;
  int mismatched = 0;

  // bench model
  logic [ADDR_W-1:0] mAe, mAf;
  logic mSerial = 1'b0;
  logic mWrPtr = 1'b0, mRdPtr = 1'b0;
  int   mBit = 0;

  logic [DATA_W-1:0] expQ[$];
  string tagQ[$];

  always #2.5 wrClk = ~wrClk;
  initial begin
    #1.25;
    forever #2.5 rdClk = ~rdClk;
  end

  flag_offset_prog u_flag_offset_prog (
    .wrClk(wrClk), .rdClk(rdClk), .mrsN(mrsN), .prsN(prsN), .loadSel(loadSel),
    .ld(ld), .wrEn(wrEn), .din(din), .serEn(serEn), .serIn(serIn),
    .rdEn(rdEn), .dout(dout)
  );

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: dout=%h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares every readback against the scoreboard
  always @(posedge rdClk) begin
    if (mrsN && prsN && rdEn && ld) begin
      #1;
      if (expQ.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL R6: unexpected readback dout=%h expected none", dout);
      end else begin
        check(tagQ.pop_front(), dout, expQ.pop_front());
      end
    end
  end

  task automatic masterReset(logic sel);
    @(negedge wrClk);
    mrsN = 1'b0; loadSel = sel;
    repeat (3) @(negedge wrClk);
    mrsN = 1'b1;
    mAe = sel ? 12'd1023 : 12'd127;
    mAf = mAe;
    mSerial = sel; mWrPtr = 1'b0; mRdPtr = 1'b0; mBit = 0;
    repeat (2) @(negedge wrClk);
  endtask

  task automatic partialReset();
    @(negedge wrClk);
    prsN = 1'b0;
    repeat (3) @(negedge wrClk);
    prsN = 1'b1;
    mWrPtr = 1'b0; mRdPtr = 1'b0; mBit = 0;
    repeat (2) @(negedge wrClk);
  endtask

  task automatic parWrite(logic [DATA_W-1:0] d, logic en, logic l);
    @(negedge wrClk);
    din = d; wrEn = en; ld = l;
    if (en && l && !mSerial) begin
      if (!mWrPtr) mAe = d[ADDR_W-1:0];
      else         mAf = d[ADDR_W-1:0];
      mWrPtr = ~mWrPtr;
    end
    @(negedge wrClk);
    wrEn = 1'b0; ld = 1'b0;
  endtask

  task automatic serBit(logic b);
    @(negedge wrClk);
    serEn = 1'b1; ld = 1'b1; serIn = b;
    if (mSerial) begin
      if (mBit < ADDR_W) mAe[mBit] = b;
      else               mAf[mBit - ADDR_W] = b;
      mBit = (mBit == 2*ADDR_W - 1) ? 0 : mBit + 1;
    end
    @(negedge wrClk);
    serEn = 1'b0; ld = 1'b0;
  endtask

  task automatic serWord(logic [ADDR_W-1:0] w);
    for (int i = 0; i < ADDR_W; i++) serBit(w[i]);
  endtask

  task automatic readBack(string tag);
    @(negedge rdClk);
    expQ.push_back(DATA_W'(mRdPtr ? mAf : mAe));
    tagQ.push_back(tag);
    mRdPtr = ~mRdPtr;
    rdEn = 1'b1; ld = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0; ld = 1'b0;
    @(negedge rdClk);
  endtask

  initial begin
    #1000000;
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R9 / R1: reset state and small defaults, parallel mode
    masterReset(1'b0);
    @(negedge rdClk);
    check("R9 reset dout", dout, '0);
    readBack("R1 small default AE");
    readBack("R1 small default AF");

    // R2 / R6: alternate writes, upper din bits dropped, zero-extended readback
    parWrite(18'h3F0A5, 1, 1);
    parWrite(18'h2A3C1, 1, 1);
    readBack("R2 AE write");
    readBack("R2 AF write");
    parWrite(18'h00123, 1, 1);
    readBack("R2 wrap AE");
    readBack("R6 AF order");

    // R3 / R5: half strobes and serial strobes have no effect
    parWrite(18'h00FFF, 1, 0);
    parWrite(18'h00EEE, 0, 1);
    for (int i = 0; i < 4; i++) serBit(1'b1);
    readBack("R3 AE unchanged");
    readBack("R5 AF unchanged");

    // R8: partial reset in parallel mode
    parWrite(18'h00777, 1, 1);
    readBack("R8 before prs AE");
    partialReset();
    parWrite(18'h00555, 1, 1);
    readBack("R8 AE after prs");
    readBack("R8 AF kept");

    // R1 / R7: large defaults, serial mode readback
    masterReset(1'b1);
    readBack("R7 large default AE");
    readBack("R1 large default AF");

    // R4: serial fill, then wrap into AE low bits
    serWord(12'hABC);
    serWord(12'h5A5);
    parWrite(18'h00111, 1, 1);
    readBack("R4 serial AE");
    readBack("R3 serial AF, parallel ignored");
    serBit(1'b1); serBit(1'b1); serBit(1'b0); serBit(1'b0); serBit(1'b1);
    readBack("R4 wrap AE");
    readBack("R4 wrap AF");

    // R8: partial reset in mid-serial load keeps mode, restarts at AE bit 0
    serBit(1'b0); serBit(1'b1); serBit(1'b0);
    partialReset();
    serWord(12'h0F0);
    parWrite(18'h00222, 1, 1);
    readBack("R8 serial restart AE");
    readBack("R8 mode kept AF");

    // R1: master reset overrides programming
    masterReset(1'b0);
    @(negedge rdClk);
    check("R9 dout cleared", dout, '0);
    readBack("R1 override AE");
    readBack("R1 override AF");

    repeat (4) @(negedge rdClk);
    if (expQ.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL R6: %0d readbacks missing, expected 0", expQ.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule